// File: doc/BRIEF.md
# Software-Loaded Translation Lookaside Buffer

This block is a small, fully associative address translation cache for an I/O or coprocessor memory management unit. Each entry pairs a match half (a virtual tag, a page size code, a valid flag and a keep-on-flush flag) with a data half (a physical frame number and three access attributes). Entries are loaded only by register writes. Software places a match word and a data word in two staging registers, sets the replacement pointer if it needs to, and writes a load command. The staged pair is then copied into the entry that the pointer selects.

Every lookup presents a 32-bit virtual address. The block compares it against all valid entries, and each entry uses its own page size to decide how many tag bits take part. The result appears one cycle later as either a hit, with the physical address and the attributes, or a miss. A flush command drops every entry that is not marked to be kept. A lock base reserves the low entries, so the automatic advance of the replacement pointer after each load never returns to them.

Top module: `sl_tlb`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and the replacement pointer and the lock base are both 0.
- R2: Writing a word with bit 0 set to the load register (offset 0x54) copies the staged match word (offset 0x58) and the staged data word (offset 0x5C) into the entry at the replacement pointer. Writing the same register with bit 0 clear loads nothing and leaves the pointer unchanged.
- R3: The match word holds the tag in bits 31:12, the size code in bits 1:0, valid in bit 2 and keep in bit 3. The size codes are 0 = 1 MB (tag bits 31:20 compared), 1 = 64 KB (31:16), 2 = 4 KB (31:12) and 3 = 16 MB (31:24). A valid entry hits exactly when the compared bits are equal.
- R4: On a hit the physical address takes its bits above the page offset from the entry's frame and its page-offset bits from the virtual address.
- R5: The data word holds the frame in bits 31:12, endianness in bit 9, element size in bits 8:7 and the mixed flag in bit 6. On a hit these three attributes are returned unchanged.
- R6: An entry loaded with valid = 0 never hits.
- R7: Writing bit 0 = 1 to the flush register (offset 0x60) clears valid on every entry whose keep bit is 0. Entries whose keep bit is 1 still hit afterwards.
- R8: The lock register (offset 0x50) sets the pointer from bits 4:0 and the lock base from bits 20:16. Each load advances the pointer by one, and a load at the last entry (31) wraps the pointer to the lock base. Entries below the base are therefore not overwritten by consecutive loads, and the pointer is output as `victim_o`.
- R9: When more than one entry hits, the entry with the lowest index supplies the translation.
- R10: The result of a lookup appears in the cycle after the request. `hit_o` and `miss_o` are never both high, and both are low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 32 | Register write data |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| hit_o | output | 1 | Lookup hit, one cycle after the request |
| miss_o | output | 1 | Lookup miss, one cycle after the request |
| pa_o | output | 32 | Translated physical address |
| endian_o | output | 1 | Endianness attribute of the hit entry |
| elem_size_o | output | 2 | Element size attribute of the hit entry |
| mixed_o | output | 1 | Mixed-size attribute of the hit entry |
| victim_o | output | 5 | Current replacement pointer |

## Verification
For one entry of each page size, the bench flips every virtual address bit from 12 to 31 in turn. A design that masked the tag at the wrong boundary would hit where it should miss, or the reverse, and a wrong page-offset splice would produce a corrupted physical address. Overlapping entries check that the lowest index wins, so a priority encoder that picked the highest index would return the wrong frame. The flush check includes both a kept entry and a non-kept entry, and would catch a flush that cleared everything or one that ignored the keep flag. The pointer is run up to the last entry with a nonzero lock base, and would expose a wrap to 0 that overwrites locked entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TAG_W = 20;

  localparam logic [7:0] OFF_LOCK  = 8'h50;
  localparam logic [7:0] OFF_LOAD  = 8'h54;
  localparam logic [7:0] OFF_CAM   = 8'h58;
  localparam logic [7:0] OFF_RAM   = 8'h5C;
  localparam logic [7:0] OFF_FLUSH = 8'h60;

  typedef enum logic [1:0] {
    PG_1M   = 2'd0,
    PG_64K  = 2'd1,
    PG_4K   = 2'd2,
    PG_16M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    pg_size_e         size;
    logic             valid;
    logic             keep;
  } cam_t;

  typedef struct packed {
    logic [TAG_W-1:0] frame;
    logic             endian;
    logic [1:0]       elsize;
    logic             mixed;
  } ram_t;

  // 1 marks a tag bit that takes part in the compare
  function automatic logic [TAG_W-1:0] tag_mask(input pg_size_e sz);
    case (sz)
      PG_4K:   tag_mask = 20'hFFFFF;
      PG_64K:  tag_mask = 20'hFFFF0;
      PG_1M:   tag_mask = 20'hFFF00;
      default: tag_mask = 20'hFF000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output cam_t             cam_stage_o,
  output ram_t             ram_stage_o,
  output logic [IDX_W-1:0] victim_o,
  output logic             load_o,
  output logic             flush_o
);
  logic [IDX_W-1:0] victim_q, base_q;
  cam_t cam_q;
  ram_t ram_q;
  logic unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign load_o  = wr_en_i && (wr_addr_i == OFF_LOAD)  && wr_data_i[0];
  assign flush_o = wr_en_i && (wr_addr_i == OFF_FLUSH) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cam_q <= '0;
      ram_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFF_CAM)
        cam_q <= '{tag: wr_data_i[31:12], size: pg_size_e'(wr_data_i[1:0]),
                   valid: wr_data_i[2], keep: wr_data_i[3]};
      if (wr_addr_i == OFF_RAM)
        ram_q <= '{frame: wr_data_i[31:12], endian: wr_data_i[9],
                   elsize: wr_data_i[8:7], mixed: wr_data_i[6]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
      base_q   <= '0;
    end else if (wr_en_i && wr_addr_i == OFF_LOCK) begin
      victim_q <= wr_data_i[IDX_W-1:0];
      base_q   <= wr_data_i[16 +: IDX_W];
    end else if (load_o) begin
      victim_q <= (victim_q == IDX_W'(ENTRIES-1)) ? base_q : victim_q + 1'b1;
    end
  end

  assign cam_stage_o = cam_q;
  assign ram_stage_o = ram_q;
  assign victim_o    = victim_q;

  assert_wrap_to_base_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_o) && $past(victim_q) == IDX_W'(ENTRIES-1) |-> victim_q == $past(base_q));
  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_o) && $past(victim_q) != IDX_W'(ENTRIES-1) |-> victim_q == $past(victim_q) + 1'b1);
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      flush_i,
  input  logic [IDX_W-1:0]          victim_i,
  input  cam_t                      cam_stage_i,
  input  ram_t                      ram_stage_i,
  input  logic [TAG_W-1:0]          va_tag_i,
  output logic [ENTRIES-1:0]        match_o,
  output ram_t [ENTRIES-1:0]        ram_o,
  output pg_size_e [ENTRIES-1:0]    size_o
);
  logic [ENTRIES-1:0] valid_vec, keep_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    cam_t cam_q;
    ram_t ram_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cam_q <= '0;
        ram_q <= '0;
      end else if (load_i && victim_i == IDX_W'(i)) begin
        cam_q <= cam_stage_i;
        ram_q <= ram_stage_i;
      end else if (flush_i && !cam_q.keep) begin
        cam_q.valid <= 1'b0;
      end
    end
    assign valid_vec[i] = cam_q.valid;
    assign keep_vec[i]  = cam_q.keep;
    assign match_o[i]   = cam_q.valid &&
                          (((va_tag_i ^ cam_q.tag) & tag_mask(cam_q.size)) == '0);
    assign ram_o[i]     = ram_q;
    assign size_o[i]    = cam_q.size;
  end

  assert_flush_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (($past(valid_vec & keep_vec)) & ~valid_vec) == '0);
  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (valid_vec & ~keep_vec) == '0);
  assert_load_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> valid_vec[$past(victim_i)] == $past(cam_stage_i.valid));
  assert_invalid_no_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o & ~valid_vec) == '0);
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] req_i,
  output logic [ENTRIES-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  assign grant_o = req_i & (~req_i + 1'b1);
  assign any_o   = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IDX_W'(i);
  end

  assert_one_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> grant_o[idx_o] && ((req_i & ((ENTRIES'(1) << idx_o) - 1'b1)) == '0));
endmodule

// File: rtl/sl_tlb.sv
module sl_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_va_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [31:0]      pa_o,
  output logic             endian_o,
  output logic [1:0]       elem_size_o,
  output logic             mixed_o,
  output logic [IDX_W-1:0] victim_o
);
  cam_t cam_stage;
  ram_t ram_stage;
  logic load, flush;
  logic [ENTRIES-1:0] match, grant;
  ram_t [ENTRIES-1:0] ram_all;
  pg_size_e [ENTRIES-1:0] size_all;
  logic [IDX_W-1:0] win_idx;
  logic any_hit;
  ram_t win_ram;
  logic [TAG_W-1:0] win_mask, pa_hi;
  logic unused_grant;

  tlb_regs #(.ENTRIES(ENTRIES)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cam_stage_o(cam_stage), .ram_stage_o(ram_stage),
    .victim_o, .load_o(load), .flush_o(flush)
  );

  tlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk_i, .rst_ni, .load_i(load), .flush_i(flush), .victim_i(victim_o),
    .cam_stage_i(cam_stage), .ram_stage_i(ram_stage),
    .va_tag_i(lk_va_i[31:12]), .match_o(match), .ram_o(ram_all), .size_o(size_all)
  );

  tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
    .clk_i, .rst_ni, .req_i(match), .grant_o(grant), .idx_o(win_idx), .any_o(any_hit)
  );

  assign unused_grant = ^grant;
  assign win_ram  = ram_all[win_idx];
  assign win_mask = tag_mask(size_all[win_idx]);
  assign pa_hi    = (win_ram.frame & win_mask) | (lk_va_i[31:12] & ~win_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      pa_o        <= '0;
      endian_o    <= 1'b0;
      elem_size_o <= '0;
      mixed_o     <= 1'b0;
    end else begin
      hit_o  <= lk_valid_i && any_hit;
      miss_o <= lk_valid_i && !any_hit;
      if (lk_valid_i && any_hit) begin
        pa_o        <= {pa_hi, lk_va_i[11:0]};
        endian_o    <= win_ram.endian;
        elem_size_o <= win_ram.elsize;
        mixed_o     <= win_ram.mixed;
      end
    end
  end

  assert_hit_miss_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));
  assert_resp_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o) |-> $past(lk_valid_i));
  assert_req_gets_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (hit_o || miss_o));
endmodule

// File: tb/tb_sl_tlb.sv
`timescale 1ns/1ps
module tb_sl_tlb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, lk_valid = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0, lk_va = '0;
  logic hit, miss, endian, mixed;
  logic [31:0] pa;
  logic [1:0] elsize;
  logic [4:0] victim;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic s_hit, s_miss, s_end, s_mx;
  logic [31:0] s_pa;
  logic [1:0] s_es;

  always #4 clk = ~clk;

  sl_tlb dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
    .hit_o(hit), .miss_o(miss), .pa_o(pa), .endian_o(endian),
    .elem_size_o(elsize), .mixed_o(mixed), .victim_o(victim)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    s_hit = hit; s_miss = miss; s_pa = pa; s_end = endian; s_es = elsize; s_mx = mixed;
    lk_valid = 1'b0;
  endtask

  function automatic int low_bits(input logic [1:0] code);
    case (code)
      2'd0: return 20;
      2'd1: return 16;
      2'd2: return 12;
      default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] exp_pa(input logic [1:0] code, input logic [19:0] frame,
                                         input logic [31:0] va);
    logic [31:0] m;
    m = (32'd1 << low_bits(code)) - 1;
    return ({frame, 12'h000} & ~m) | (va & m);
  endfunction

  task automatic load(input logic [31:0] va, input logic [1:0] code, input bit vld,
                      input bit keep, input logic [19:0] frame, input logic [3:0] attr);
    wr(8'h58, {va[31:12], 8'h00, keep, vld, code});
    wr(8'h5C, {frame, 2'b00, attr[3], attr[2:1], attr[0], 6'h00});
    wr(8'h54, 32'h1);
  endtask

  logic [1:0]  e_code [4];
  logic [31:0] e_va   [4];
  logic [19:0] e_fr   [4];
  logic [3:0]  e_attr [4];

  initial begin
    e_code[0] = 2'd2; e_code[1] = 2'd1; e_code[2] = 2'd0; e_code[3] = 2'd3;
    for (int k = 0; k < 4; k++) begin
      e_va[k]   = {8'(1 << k), 12'hABC, 12'h345};
      e_fr[k]   = 20'h9_0000 + 20'(k * 20'h1357);
      e_attr[k] = {k[0], 2'(k), ~k[0]};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 victim after reset", 32'(victim), 0);
    lookup(e_va[0]);
    check("R1 miss after reset", {s_hit, s_miss}, 2'b01);
    @(negedge clk);
    check("R10 idle no hit/miss", {hit, miss}, 2'b00);

    for (int k = 0; k < 4; k++) begin
      load(e_va[k], e_code[k], 1'b1, k == 1, e_fr[k], e_attr[k]);
      check("R8 victim advance", 32'(victim), 32'(k + 1));
    end

    for (int k = 0; k < 4; k++) begin
      lookup(e_va[k]);
      check("R3 base hit", {s_hit, s_miss}, 2'b10);
      check("R4 base pa", s_pa, exp_pa(e_code[k], e_fr[k], e_va[k]));
      check("R5 attrs", {s_end, s_es, s_mx}, e_attr[k]);
      for (int b = 12; b < 32; b++) begin
        logic [31:0] v;
        v = e_va[k] ^ (32'd1 << b);
        lookup(v);
        if (b < low_bits(e_code[k])) begin
          check("R3 offset bit hit", {s_hit, s_miss}, 2'b10);
          check("R4 pa splice", s_pa, exp_pa(e_code[k], e_fr[k], v));
        end else begin
          check("R3 tag bit miss", {s_hit, s_miss}, 2'b01);
        end
      end
    end

    load(32'h4000_0000, 2'd3, 1'b0, 1'b0, 20'h11111, 4'h0);
    lookup(32'h4012_3456);
    check("R6 invalid entry misses", {s_hit, s_miss}, 2'b01);

    load(32'h0100_0000, 2'd3, 1'b1, 1'b0, 20'h77700, 4'hF);
    check("R8 victim at 6", 32'(victim), 6);
    lookup(e_va[0]);
    check("R9 lowest index hit", {s_hit, s_miss}, 2'b10);
    check("R9 lowest index pa", s_pa, exp_pa(2'd2, e_fr[0], e_va[0]));
    check("R9 lowest index attrs", {s_end, s_es, s_mx}, e_attr[0]);
    lookup(32'h0112_3456);
    check("R9 only upper entry", s_pa, 32'h7712_3456);

    wr(8'h60, 32'h1);
    lookup(e_va[0]);
    check("R7 flushed entry misses", {s_hit, s_miss}, 2'b01);
    lookup(32'h0112_3456);
    check("R7 flushed entry5 misses", {s_hit, s_miss}, 2'b01);
    lookup(e_va[3]);
    check("R7 flushed entry3 misses", {s_hit, s_miss}, 2'b01);
    lookup(e_va[1]);
    check("R7 kept entry hits", {s_hit, s_miss}, 2'b10);
    check("R7 kept entry pa", s_pa, exp_pa(e_code[1], e_fr[1], e_va[1]));

    wr(8'h58, {20'h20000, 8'h00, 4'b0110});
    wr(8'h5C, {20'h55555, 12'h000});
    wr(8'h54, 32'h0);
    check("R2 load with bit0 clear keeps victim", 32'(victim), 6);
    lookup(32'h2000_0123);
    check("R2 load with bit0 clear no entry", {s_hit, s_miss}, 2'b01);
    wr(8'h54, 32'h1);
    check("R2 load victim advance", 32'(victim), 7);
    lookup(32'h2000_0123);
    check("R2 staged entry loaded", s_pa, 32'h5555_5123);

    wr(8'h50, (32'd30 << 16) | 32'd30);
    check("R8 lock write victim", 32'(victim), 30);
    load(32'h2100_0000, 2'd2, 1'b1, 1'b0, 20'hA1000, 4'h0);
    check("R8 victim 31", 32'(victim), 31);
    load(32'h2200_0000, 2'd2, 1'b1, 1'b0, 20'hA2000, 4'h0);
    check("R8 wrap to base", 32'(victim), 30);
    load(32'h2300_0000, 2'd2, 1'b1, 1'b0, 20'hA3000, 4'h0);
    lookup(32'h2100_0000);
    check("R8 overwritten at base", {s_hit, s_miss}, 2'b01);
    lookup(32'h2300_0ABC);
    check("R8 new entry at base", s_pa, 32'hA300_0ABC);
    lookup(32'h2200_0001);
    check("R8 entry 31 kept", s_pa, 32'hA200_0001);
    lookup(32'h2000_0123);
    check("R8 locked entry kept", {s_hit, s_miss}, 2'b10);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule